// File: doc/BRIEF.md
# CAN Controller Interrupt Flag Unit

This block sits beside a CAN protocol core. It turns the core's events and state into a small set of sticky interrupt flags. The core supplies four kinds of input:
- a pulse each time a received message lands in the foreground slot of the receive queue;
- a level while the receive queue is overrun;
- bus activity together with the sleep handshake and wake-up option;
- the transmit and receive error counters, plus a bus-off indication.

The block derives a 2-bit state code for the transmitter and for the receiver from those counters. It raises a change flag whenever either code moves.

Software reaches the block through a two-location register port. Location 0 returns the four flags and both state codes. Writing ones to location 0 clears flags. Location 1 holds the per-flag enable mask. A registered interrupt request is raised whenever any enabled flag is set. A flag whose cause is still present cannot be cleared, and an event always wins over a clear in the same cycle. Because of this, a flag that is cleared is never one that software has not yet seen.

Top module: `can_irq_flags`

## Requirements
- R1: After reset, all four flags, the enable mask, both state codes and `irq` read as zero.
- R2: A write to location 0 clears each flag whose data bit is 1. Data bits that are 0 leave their flags unchanged. The flag bits are: bit 0 receive, bit 1 overrun, bit 2 wake-up, bit 3 state change.
- R3: A clear is ignored in any cycle where that flag's setting condition is present. The flag stays 1 after that cycle.
- R4: A `rx_load` pulse sets the receive flag on the next clock edge. Each later pulse sets it again after it was cleared.
- R5: The overrun flag is set on every edge where `ovr_cond` is high. It stays set after `ovr_cond` falls, until it is cleared.
- R6: The wake-up flag is set only in a cycle where all five of these are high: `bus_act`, `slp_req`, `slp_ack`, `wup_opt`, and enable bit 2. If any one is low, it stays clear.
- R7: Transmitter code is 11 when `bus_off` is high. Otherwise it is 10 for a count of 128 or more, 01 for 96 to 127, and 00 below 96. It is registered on each edge.
- R8: Receiver code uses the same thresholds without bus-off: 10, 01 or 00. It never reads 11, even for counts above 255.
- R9: The state-change flag is set on an edge where either newly computed code differs from the code registered on the previous edge.
- R10: Location 1 is read/write in bits 3:0 and reads 0 in bits 7:4. `irq` equals, one edge later, the OR of the flag register ANDed with the enable mask.
- R11: Location 0 reads {tx code[7:6], rx code[5:4], flags[3:0]}. The read data is combinational from `reg_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_load | input | 1 | Pulse: a message moved into the foreground receive slot |
| ovr_cond | input | 1 | Level: receive queue overrun present |
| bus_act | input | 1 | Level: activity seen on the CAN bus |
| slp_req | input | 1 | Sleep requested |
| slp_ack | input | 1 | Sleep acknowledged |
| wup_opt | input | 1 | Wake-up option enabled |
| tx_cnt | input | CNT_W | Transmit error counter |
| rx_cnt | input | CNT_W | Receive error counter |
| bus_off | input | 1 | Core is in bus-off |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = flags/status, 1 = enable mask |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data |
| irq | output | 1 | Registered interrupt request |

## Verification
Every flag, the enable mask and both state codes change on the first clock edge after their stimulus. `irq` follows one edge after that, because it is registered from the flag and mask registers. Stimulus is driven on falling edges. A reference model steps on each rising edge, and 2 ns later the read port and `irq` are compared against it. The directed checks read the port at the falling edge that follows the effective rising edge, and read `irq` one full cycle later.

// File: rtl/can_irq_flags.sv
module can_irq_flags #(
  parameter int CNT_W    = 9,
  parameter int WARN_LIM = 96,
  parameter int PASS_LIM = 128,
  parameter int DW       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_load,
  input  logic             ovr_cond,
  input  logic             bus_act,
  input  logic             slp_req,
  input  logic             slp_ack,
  input  logic             wup_opt,
  input  logic [CNT_W-1:0] tx_cnt,
  input  logic [CNT_W-1:0] rx_cnt,
  input  logic             bus_off,
  input  logic             reg_wr,
  input  logic             reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  output logic             irq
);
  localparam int NF = 4;
  localparam logic [1:0] ST_OK = 2'd0, ST_WARN = 2'd1, ST_PASS = 2'd2, ST_OFF = 2'd3;

  logic [NF-1:0] flags_q, en_q, set_c, clr_c, flags_d;
  logic [1:0]    txs_c, rxs_c, txs_q, rxs_q;
  logic          wake_ok;

  assign wake_ok = bus_act & slp_req & slp_ack & wup_opt & en_q[2];

  assign txs_c = bus_off                        ? ST_OFF  :
                 (tx_cnt >= CNT_W'(PASS_LIM))   ? ST_PASS :
                 (tx_cnt >= CNT_W'(WARN_LIM))   ? ST_WARN : ST_OK;
  assign rxs_c = (rx_cnt >= CNT_W'(PASS_LIM))   ? ST_PASS :
                 (rx_cnt >= CNT_W'(WARN_LIM))   ? ST_WARN : ST_OK;

  assign set_c   = {(txs_c != txs_q) | (rxs_c != rxs_q), wake_ok, ovr_cond, rx_load};
  assign clr_c   = (reg_wr && !reg_addr) ? reg_wdata[NF-1:0] : '0;
  assign flags_d = set_c | (flags_q & ~clr_c);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      en_q    <= '0;
      txs_q   <= ST_OK;
      rxs_q   <= ST_OK;
      irq     <= 1'b0;
    end else begin
      flags_q <= flags_d;
      txs_q   <= txs_c;
      rxs_q   <= rxs_c;
      irq     <= |(flags_q & en_q);
      if (reg_wr && reg_addr) en_q <= reg_wdata[NF-1:0];
    end
  end

  assign reg_rdata = reg_addr ? DW'(en_q) : DW'({txs_q, rxs_q, flags_q});

  assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_addr && reg_wdata[0] && !rx_load) |=> !flags_q[0]);
  assert_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q[1] && !(reg_wr && !reg_addr && reg_wdata[1])) |=> flags_q[1]);
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_cond |=> flags_q[1]);
  assert_rxset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_load |=> flags_q[0]);
  assert_wake_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags_q[2]) |-> $past(bus_act && slp_req && slp_ack && wup_opt && en_q[2]));
  assert_rxcode_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rxs_q != ST_OFF);
  assert_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (txs_q != $past(txs_q)) || (rxs_q != $past(rxs_q)) |-> flags_q[3]);
  assert_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(|(flags_q & en_q)));
endmodule

// File: tb/tb_can_irq_flags.sv
module tb_can_irq_flags;
  logic clk = 0, rst_n = 0;
  logic rx_load = 0, ovr_cond = 0, bus_act = 0, slp_req = 0, slp_ack = 0, wup_opt = 0, bus_off = 0;
  logic [8:0] tx_cnt = 0, rx_cnt = 0;
  logic reg_wr = 0, reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic irq;
  int checks = 0, errors = 0;
  int m_fl = 0, m_en = 0, m_ts = 0, m_rs = 0, m_irq = 0;
  bit done = 0;

  always #4 clk = ~clk;

  can_irq_flags dut (.clk(clk), .rst_n(rst_n), .rx_load(rx_load), .ovr_cond(ovr_cond),
    .bus_act(bus_act), .slp_req(slp_req), .slp_ack(slp_ack), .wup_opt(wup_opt),
    .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .bus_off(bus_off), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    int nts, nrs, setv, clr;
    if (!rst_n) begin
      m_fl = 0; m_en = 0; m_ts = 0; m_rs = 0; m_irq = 0;
    end else begin
      nts = bus_off ? 3 : (tx_cnt >= 128) ? 2 : (tx_cnt >= 96) ? 1 : 0;
      nrs = (rx_cnt >= 128) ? 2 : (rx_cnt >= 96) ? 1 : 0;
      setv = 0;
      if (rx_load) setv |= 1;
      if (ovr_cond) setv |= 2;
      if (bus_act && slp_req && slp_ack && wup_opt && (m_en & 4) != 0) setv |= 4;
      if (nts != m_ts || nrs != m_rs) setv |= 8;
      clr = (reg_wr && !reg_addr) ? (int'(reg_wdata) & 15) : 0;
      m_irq = ((m_fl & m_en) != 0) ? 1 : 0;
      m_fl = (setv | (m_fl & ~clr)) & 15;
      if (reg_wr && reg_addr) m_en = int'(reg_wdata) & 15;
      m_ts = nts; m_rs = nrs;
    end
    #2;
    if (rst_n && !done) begin
      chk("R11 read port vs model", int'(reg_rdata),
          reg_addr ? m_en : ((m_ts << 6) | (m_rs << 4) | m_fl));
      chk("R10 irq vs model", int'(irq), m_irq);
    end
  end

  task automatic wr(bit a, logic [7:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0; reg_wdata = 0;
  endtask

  task automatic rd(bit a, output int v);
    reg_addr = a;
    #1 v = int'(reg_rdata);
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int v;
    cyc(3);
    rst_n = 1;
    rd(0, v); chk("R1 flags/status after reset", v, 0);
    rd(1, v); chk("R1 enable after reset", v, 0);
    chk("R1 irq after reset", int'(irq), 0);
    cyc(1);

    wr(1, 8'hFB);
    rd(1, v); chk("R10 enable bits 3:0 stored, 7:4 zero", v, 'h0B);

    rx_load = 1; cyc(1); rx_load = 0;
    rd(0, v); chk("R4 receive flag set", v & 1, 1);
    cyc(1); chk("R10 irq one edge after enabled flag", int'(irq), 1);
    wr(0, 8'h00);
    rd(0, v); chk("R2 write of zero keeps flag", v & 1, 1);
    wr(0, 8'h01);
    rd(0, v); chk("R2 write-one clears receive flag", v & 1, 0);
    cyc(1); chk("R10 irq drops after clear", int'(irq), 0);

    rx_load = 1; cyc(1); rx_load = 0;
    rd(0, v); chk("R4 receive flag set again by next message", v & 1, 1);
    rx_load = 1; wr(0, 8'h01); rx_load = 0;
    rd(0, v); chk("R3 load wins over same-cycle clear", v & 1, 1);
    wr(0, 8'h01);
    rd(0, v); chk("R2 receive flag cleared", v & 1, 0);

    ovr_cond = 1; cyc(1);
    wr(0, 8'h02);
    rd(0, v); chk("R3 clear ignored while overrun persists", v & 2, 2);
    ovr_cond = 0; cyc(1);
    rd(0, v); chk("R5 overrun flag sticky after cause ends", v & 2, 2);
    wr(0, 8'h02);
    rd(0, v); chk("R5 overrun flag cleared", v & 2, 0);

    bus_act = 1; slp_req = 1; slp_ack = 1; wup_opt = 1; cyc(2);
    rd(0, v); chk("R6 no wake flag with enable bit 2 low", v & 4, 0);
    wup_opt = 0; wr(1, 8'h0F); cyc(1);
    rd(0, v); chk("R6 no wake flag with option off", v & 4, 0);
    wup_opt = 1; slp_ack = 0; cyc(1);
    rd(0, v); chk("R6 no wake flag without acknowledge", v & 4, 0);
    slp_ack = 1; cyc(1);
    rd(0, v); chk("R6 wake flag with full handshake", v & 4, 4);
    bus_act = 0; slp_req = 0; slp_ack = 0; wup_opt = 0;
    wr(0, 8'h04);
    rd(0, v); chk("R2 wake flag cleared", v & 4, 0);

    tx_cnt = 95; cyc(1);
    rd(0, v); chk("R7 tx code ok below 96", (v >> 6) & 3, 0);
    chk("R9 no change flag at 95", v & 8, 0);
    tx_cnt = 96; cyc(1);
    rd(0, v); chk("R7 tx code warning at 96", (v >> 6) & 3, 1);
    chk("R9 change flag on ok->warning", v & 8, 8);
    wr(0, 8'h08);
    tx_cnt = 127; cyc(1);
    rd(0, v); chk("R9 no change inside warning band", v & 8, 0);
    tx_cnt = 128; cyc(1);
    rd(0, v); chk("R7 tx code passive at 128", (v >> 6) & 3, 2);
    bus_off = 1; cyc(1);
    rd(0, v); chk("R7 tx code bus-off", (v >> 6) & 3, 3);
    rx_cnt = 300; cyc(1);
    rd(0, v); chk("R8 rx code passive above 255", (v >> 4) & 3, 2);
    rx_cnt = 100; cyc(1);
    rd(0, v); chk("R8 rx code warning", (v >> 4) & 3, 1);
    chk("R9 change flag on rx move", v & 8, 8);
    cyc(2);
    finish_run();
  end
endmodule